// File: doc/BRIEF.md
# Immediate-Amount Barrel Shifter with Carry Output

This block forms the second operand of a 32-bit data-processing datapath. One operand word is shifted or rotated by an amount taken from a 5-bit immediate. The block also returns the bit shifted out last as a shifter carry. A flag-set input selects whether that carry, or the unchanged incoming carry, is handed back as the carry flag to commit.

The block is purely combinational: the outputs follow the inputs with no clock and no register. A 5-bit field cannot hold 32, so an immediate of zero has a meaning of its own for each shift kind:
- logical left by zero is a plain pass-through that keeps the old carry;
- logical right by zero and arithmetic right by zero mean a shift by a full 32 places;
- rotate right by zero means a one-place rotation of the 33-bit value made of the carry flag above the operand.

The block carries no data stream, so it has no valid/ready interface. Every pin is a plain level.

Top module: `imm_shifter`

## Requirements
- R1: With kind code 2'b00 (logical left) and an immediate n from 1 to 31, the result is the operand moved left by n with zeros entering at bit 0, and the shifter carry is operand bit 32-n.
- R2: With kind 2'b00 and immediate 0, the result equals the operand and the shifter carry equals the incoming carry.
- R3: With kind code 2'b01 (logical right) and n from 1 to 31, the result is the operand moved right by n with zeros entering at bit 31, and the shifter carry is operand bit n-1.
- R4: With kind 2'b01 and immediate 0, the shift is by 32: the result is all zeros and the shifter carry is operand bit 31.
- R5: With kind code 2'b10 (arithmetic right) and n from 1 to 31, the result is the operand moved right by n with copies of operand bit 31 entering at the top, and the shifter carry is operand bit n-1.
- R6: With kind 2'b10 and immediate 0, the shift is by 32: every result bit and the shifter carry equal operand bit 31.
- R7: With kind code 2'b11 (rotate right) and n from 1 to 31, the result is the operand rotated right by n, and the shifter carry equals result bit 31.
- R8: With kind 2'b11 and immediate 0, the result is the incoming carry followed by operand bits 31 down to 1, and the shifter carry is operand bit 0.
- R9: The carry to commit equals the shifter carry when the flag-set input is 1, and equals the incoming carry when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand word to shift |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| imm_i | input | 5 | Immediate shift amount |
| carry_i | input | 1 | Current carry flag |
| set_flags_i | input | 1 | High when the operation updates flags |
| result_o | output | 32 | Shifted operand |
| shcarry_o | output | 1 | Carry produced by the shifter |
| carry_wb_o | output | 1 | Carry flag value to commit |

## Verification
Two uses of the incoming carry can act in the same evaluation: the zero-immediate reinterpretation and the flag commit. A rotate-right by zero inserts the carry into result bit 31 while the shifter carry is taken from operand bit 0. A logical-left by zero keeps the old carry through both paths. The bench drives these zero-immediate cases with both carry values and with the flag-set input at both levels. A reference model computed from the requirements predicts the result, the shifter carry and the committed carry, so a case where one carry path wrongly overrides the other appears as a mismatch on one of the three outputs.

// File: rtl/shf_pkg.sv
package shf_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shkind_e;
endpackage

// File: rtl/shf_amt_decode.sv
// Maps an immediate and a shift kind to a right-rotate amount, a count of
// masked bit positions, and the rotate-through-carry marker.
module shf_amt_decode
  import shf_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  shkind_e       kind,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] rot_amt,
  output logic [AW:0]   fill_cnt,
  output logic          rrx
);
  logic imm_zero;
  assign imm_zero = (imm == '0);

  always_comb begin
    rot_amt  = imm;
    fill_cnt = '0;
    rrx      = 1'b0;
    case (kind)
      SH_LSL: begin
        rot_amt  = '0 - imm;          // left by n == right-rotate by W-n
        fill_cnt = {1'b0, imm};
      end
      SH_LSR, SH_ASR: begin
        rot_amt  = imm;
        fill_cnt = imm_zero ? (AW+1)'(W) : {1'b0, imm};
      end
      SH_ROR: begin
        rot_amt  = imm;
        rrx      = imm_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shf_rotator.sv
// Logarithmic right rotator: one stage per amount bit.
module shf_rotator #(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];
  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int D = 2 ** s;
    assign stage[s+1] = amt[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/shf_fill.sv
// Clears or sign-fills the positions vacated by a shift, or forms the
// rotate-through-carry word.
module shf_fill
  import shf_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  shkind_e      kind,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] rotated,
  input  logic [AW:0]  fill_cnt,
  input  logic         rrx,
  input  logic         cin,
  output logic [W-1:0] result
);
  logic [W-1:0] lo_mask, hi_mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign lo_mask[i] = ((AW+1)'(i) < fill_cnt);
    assign hi_mask[i] = ((AW+1)'(W - i) <= fill_cnt);
  end

  always_comb begin
    case (kind)
      SH_LSL:  result = rotated & ~lo_mask;
      SH_LSR:  result = rotated & ~hi_mask;
      SH_ASR:  result = (rotated & ~hi_mask) | (hi_mask & {W{opnd[W-1]}});
      SH_ROR:  result = rrx ? {cin, opnd[W-1:1]} : rotated;
      default: result = rotated;
    endcase
  end
endmodule

// File: rtl/shf_carry.sv
// Selects the last bit shifted out.
module shf_carry
  import shf_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  shkind_e       kind,
  input  logic [W-1:0]  opnd,
  input  logic [AW-1:0] imm,
  input  logic [AW:0]   fill_cnt,
  input  logic          rrx,
  input  logic          cin,
  input  logic          res_msb,
  output logic          cout
);
  logic [AW-1:0] left_idx, right_idx;
  assign left_idx  = '0 - imm;               // W - n
  assign right_idx = AW'(fill_cnt - 1'b1);   // n - 1, n in 1..W

  always_comb begin
    case (kind)
      SH_LSL:         cout = (imm == '0) ? cin : opnd[left_idx];
      SH_LSR, SH_ASR: cout = opnd[right_idx];
      SH_ROR:         cout = rrx ? opnd[0] : res_msb;
      default:        cout = cin;
    endcase
  end
endmodule

// File: rtl/imm_shifter.sv
module imm_shifter
  import shf_pkg::*;
#(
  parameter int W  = 32,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  opnd_i,
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] imm_i,
  input  logic          carry_i,
  input  logic          set_flags_i,
  output logic [W-1:0]  result_o,
  output logic          shcarry_o,
  output logic          carry_wb_o
);
  shkind_e       kind;
  logic [AW-1:0] rot_amt;
  logic [AW:0]   fill_cnt;
  logic          rrx;
  logic [W-1:0]  rotated;

  assign kind = shkind_e'(kind_i);

  shf_amt_decode #(.W(W)) u_dec (
    .kind(kind), .imm(imm_i), .rot_amt(rot_amt), .fill_cnt(fill_cnt), .rrx(rrx)
  );

  shf_rotator #(.W(W)) u_rot (
    .din(opnd_i), .amt(rot_amt), .dout(rotated)
  );

  shf_fill #(.W(W)) u_fill (
    .kind(kind), .opnd(opnd_i), .rotated(rotated), .fill_cnt(fill_cnt),
    .rrx(rrx), .cin(carry_i), .result(result_o)
  );

  shf_carry #(.W(W)) u_car (
    .kind(kind), .opnd(opnd_i), .imm(imm_i), .fill_cnt(fill_cnt), .rrx(rrx),
    .cin(carry_i), .res_msb(result_o[W-1]), .cout(shcarry_o)
  );

  assign carry_wb_o = set_flags_i ? shcarry_o : carry_i;

  always_comb begin
    if (imm_i == '0) begin
      if (kind == SH_LSL) begin
        // R2
        lsl_zero_pass_chk: assert (result_o == opnd_i && shcarry_o == carry_i);
      end
      if (kind == SH_LSR) begin
        // R4
        lsr_full_zero_chk: assert (result_o == '0 && shcarry_o == opnd_i[W-1]);
      end
      if (kind == SH_ASR) begin
        // R6
        asr_full_sign_chk: assert (result_o == {W{opnd_i[W-1]}} && shcarry_o == opnd_i[W-1]);
      end
      if (kind == SH_ROR) begin
        // R8
        rrx_form_chk: assert (result_o[W-1] == carry_i && shcarry_o == opnd_i[0]);
      end
      if (kind == SH_LSL && set_flags_i) begin
        // R9
        lsl_zero_keeps_c_chk: assert (carry_wb_o == carry_i);
      end
    end
  end
endmodule

// File: tb/imm_shifter_bench.sv
module imm_shifter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd;
  logic [1:0]  kind;
  logic [4:0]  imm;
  logic        cin, fset;
  logic [31:0] res;
  logic        shc, cwb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        co;
    logic        wb;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;   // 125 MHz

  imm_shifter u_imm_shifter (
    .opnd_i(opnd), .kind_i(kind), .imm_i(imm), .carry_i(cin),
    .set_flags_i(fset), .result_o(res), .shcarry_o(shc), .carry_wb_o(cwb)
  );

  function automatic exp_t model(logic [31:0] op, logic [1:0] k,
                                 logic [4:0] im, logic c, logic f);
    exp_t e;
    logic [32:0] t;
    int n;
    n = int'(im);
    case (k)
      2'b00: begin
        if (n == 0) begin e.r = op; e.co = c; e.tag = "R2"; end
        else begin t = {1'b0, op} << n; e.r = t[31:0]; e.co = t[32]; e.tag = "R1"; end
      end
      2'b01: begin
        e.tag = (n == 0) ? "R4" : "R3";
        if (n == 0) n = 32;
        t = {op, 1'b0} >> n; e.r = t[32:1]; e.co = t[0];
      end
      2'b10: begin
        e.tag = (n == 0) ? "R6" : "R5";
        if (n == 0) n = 32;
        t = 33'($signed({op, 1'b0}) >>> n); e.r = t[32:1]; e.co = t[0];
      end
      default: begin
        if (n == 0) begin e.r = {c, op[31:1]}; e.co = op[0]; e.tag = "R8"; end
        else begin e.r = (op >> n) | (op << (32 - n)); e.co = e.r[31]; e.tag = "R7"; end
      end
    endcase
    e.wb = f ? e.co : c;
    if (f) e.tag = {e.tag, "/R9"};
    return e;
  endfunction

  task automatic drive(logic [31:0] op, logic [1:0] k, logic [4:0] im, logic c, logic f);
    @(posedge clk);
    #1;
    opnd = op; kind = k; imm = im; cin = c; fset = f;
    sb.push_back(model(op, k, im, c, f));
  endtask

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_cmp++;
      if (res !== e.r || shc !== e.co || cwb !== e.wb) begin
        n_bad++;
        $display("FAIL %s op=%h kind=%0d imm=%0d c=%0b f=%0b: got r=%h co=%0b wb=%0b exp r=%h co=%0b wb=%0b",
                 e.tag, opnd, kind, imm, cin, fset, res, shc, cwb, e.r, e.co, e.wb);
      end
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001;
    pats[1] = 32'h7FFF_FFFE;
    pats[2] = 32'hDEAD_BEEF;
    pats[3] = 32'h1234_5678;
    opnd = '0; kind = 2'b00; imm = '0; cin = 1'b0; fset = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // reset-state check: all-zero inputs give all-zero outputs (R2)
    n_cmp++;
    if (res !== '0 || shc !== 1'b0 || cwb !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 idle: got r=%h co=%0b wb=%0b exp 0/0/0", res, shc, cwb);
    end
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int cf = 0; cf < 4; cf++) begin
          drive(pats[p], 2'(k), 5'd0,  cf[0], cf[1]);
          drive(pats[p], 2'(k), 5'd1,  cf[0], cf[1]);
          drive(pats[p], 2'(k), 5'd31, cf[0], cf[1]);
          drive($urandom, 2'(k), 5'($urandom_range(2, 30)), cf[0], cf[1]);
        end
      end
    end
    for (int i = 0; i < 200; i++)
      drive($urandom, 2'($urandom), 5'($urandom), 1'($urandom), 1'($urandom));
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule